// File: doc/BRIEF.md
# Byte-Command Register Access Parser

This block sits between a byte-wide serial receiver/transmitter pair and a bank of 128 byte-wide registers. A host addresses the bank with a single command byte. The upper seven bits of that byte select the starting register, and the lowest bit selects the direction. A read command is followed by one count byte. The parser then fetches that many bytes from ascending addresses and passes them to the transmitter one at a time. A write command is followed by any number of data bytes, which are stored at ascending addresses. The write burst ends when the line has been idle for longer than a parameterised number of clock cycles. After that, the next received byte is decoded as a new command.

Multi-byte registers are laid out with their most significant byte at the lower address, so an ascending walk returns the most significant byte first. The register bank sits outside the block. It is reached through a port with a single address, a one-cycle write strobe and a read strobe whose data comes back on the following cycle, which matches an inferred block RAM.

Top module: `ureg_cmd_parser`

## Requirements
- R1: After a synchronous reset, `tx_valid`, `reg_we` and `reg_rd_en` are low, and the next received byte is treated as a command byte.
- R2: In a command byte, bits 7:1 give the register address (0..127) and bit 0 gives the direction, with 1 for read and 0 for write. The byte 0x82 therefore writes address 0x41 and 0x83 reads it.
- R3: After a write command, each received byte produces exactly one `reg_we` pulse one cycle later. The bytes are stored at the commanded address and then at ascending addresses.
- R4: A write burst continues across idle gaps of up to GAP_CYCLES-2 cycles. Once the line has been idle for more than GAP_CYCLES cycles, the next byte is decoded as a command.
- R5: After a read command, a count byte N causes exactly N bytes to be sent, taken from the commanded address upward. The lower address holds the more significant byte, so data leaves most significant byte first.
- R6: A count byte of zero sends nothing, and the next byte is decoded as a command.
- R7: The address pointer wraps from 127 to 0 in both read and write bursts.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold steady. No byte is lost or repeated under backpressure.
- R9: Bytes received while a read response is in progress are ignored: they cause no write and do not change the response.
- R10: If no count byte arrives within the idle limit after a read command, the parser returns to waiting for a command.
- R11: Each byte sent costs exactly one single-cycle `reg_rd_en` pulse. Its data is expected on `reg_rdata` in the next cycle, and the byte appears on `tx_valid` the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| reg_addr | output | 7 | Register bank address |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid one cycle after the strobe |

## Verification
A corrupted address pointer shows up as a wrong byte in the first or second byte of any read-back. A lost direction bit turns a read into a write, so no response appears and later read-backs show altered contents. A stuck or short idle timer either swallows the following command as write data or splits a paced write burst. Either effect appears in the read-back of the very next command. Errors in the count or the handshake appear within a few cycles of the response, as an extra byte, a missing byte, or data that changes while the transmitter is stalled.

// File: rtl/ureg_pkg.sv
package ureg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    S_CMD,
    S_LEN,
    S_WR,
    S_RREQ,
    S_RCAP,
    S_SEND
  } pstate_t;
endpackage

// File: rtl/ureg_gap_timer.sv
module ureg_gap_timer #(
  parameter int GAP_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic kick,
  output logic expired
);
  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || kick) begin
      cnt <= '0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = arm && !kick && (cnt == LIMIT);
endmodule

// File: rtl/ureg_tx_stage.sv
module ureg_tx_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         taken
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load && !tx_valid) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  assign taken = tx_valid && tx_ready;
endmodule

// File: rtl/ureg_cmd_parser.sv
module ureg_cmd_parser
  import ureg_pkg::*;
#(
  parameter int GAP_CYCLES = 32,
  parameter int LEN_W      = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd_en,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  pstate_t           state;
  logic [ADDR_W-1:0] ptr;
  logic [LEN_W-1:0]  remain;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              rd_q;
  logic              gap_exp;
  logic              tx_taken;
  logic              tx_load;

  // The idle timer only runs while the parser waits for a count byte or write data.
  ureg_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .arm     ((state == S_LEN) || (state == S_WR)),
    .kick    (rx_valid),
    .expired (gap_exp)
  );

  assign tx_load = (state == S_RCAP);

  ureg_tx_stage #(.W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (tx_load),
    .load_data (reg_rdata),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .taken     (tx_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_CMD;
      ptr     <= '0;
      remain  <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      rd_q <= 1'b0;
      unique case (state)
        S_CMD: begin
          if (rx_valid) begin
            ptr   <= rx_data[BYTE_W-1:1];
            state <= rx_data[0] ? S_LEN : S_WR;
          end
        end
        S_LEN: begin
          if (rx_valid) begin
            remain <= LEN_W'(rx_data);
            if (rx_data == '0) begin
              state <= S_CMD;
            end else begin
              rd_q   <= 1'b1;
              addr_q <= ptr;
              state  <= S_RREQ;
            end
          end else if (gap_exp) begin
            state <= S_CMD;
          end
        end
        S_WR: begin
          if (rx_valid) begin
            we_q    <= 1'b1;
            addr_q  <= ptr;
            wdata_q <= rx_data;
            ptr     <= ptr + 1'b1;
          end else if (gap_exp) begin
            state <= S_CMD;
          end
        end
        // Read strobe is on the port during this state; data returns next cycle.
        S_RREQ: state <= S_RCAP;
        S_RCAP: state <= S_SEND;
        S_SEND: begin
          if (tx_taken) begin
            ptr    <= ptr + 1'b1;
            remain <= remain - 1'b1;
            if (remain == ONE) begin
              state <= S_CMD;
            end else begin
              rd_q   <= 1'b1;
              addr_q <= ptr + 1'b1;
              state  <= S_RREQ;
            end
          end
        end
        default: state <= S_CMD;
      endcase
    end
  end

  assign reg_addr  = addr_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_rd_en = rd_q;
endmodule

// File: rtl/ureg_cmd_parser_chk.sv
module ureg_cmd_parser_chk
  import ureg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_data,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_ready,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              reg_rd_en,
  input logic [BYTE_W-1:0] reg_rdata
);
  // R1: reset clears the outward strobes and the transmit offer.
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!tx_valid && !reg_we && !reg_rd_en));

  // R3: every write strobe follows a received byte.
  a_r3_we_follows_rx: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(rx_valid));

  // R8: an offered byte is held until taken.
  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9: no register write while a response byte is offered.
  a_r9_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !reg_we);

  // R11: read strobes are single-cycle.
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> !reg_rd_en);

  // R11: a new offer appears two cycles after its read strobe.
  a_r11_offer_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(reg_rd_en, 2));
endmodule

bind ureg_cmd_parser ureg_cmd_parser_chk u_chk (.*);

// File: tb/ureg_cmd_parser_bench.sv
`timescale 1ns/1ps
module ureg_cmd_parser_bench;
  localparam int GAP = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic [6:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic       reg_rd_en;
  logic [7:0] reg_rdata;
  logic       mem_init = 1'b1;

  logic [7:0] mem     [128];
  logic [7:0] exp_mem [128];
  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int rd_cnt = 0;

  always #2 clk = ~clk;

  ureg_cmd_parser #(.GAP_CYCLES(GAP)) u_ureg_cmd_parser (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
  );

  // Register bank model with one-cycle registered read.
  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 3 + 1);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
    if (reg_rd_en) reg_rdata <= mem[reg_addr];
    if (reg_we) we_cnt <= we_cnt + 1;
    if (reg_rd_en) rd_cnt <= rd_cnt + 1;
  end

  // {address, count} read vectors.
  localparam logic [14:0] RD_VEC [6] = '{
    {7'd5, 8'd1}, {7'd10, 8'd4}, {7'd0, 8'd2},
    {7'd100, 8'd8}, {7'd64, 8'd3}, {7'd90, 8'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic issue_read(input logic [6:0] a, input logic [7:0] n);
    send_byte({a, 1'b1});
    send_byte(n);
  endtask

  task automatic collect(input int n, input bit bp, input logic [6:0] a0, input string tag);
    int got = 0;
    int guard = 0;
    bit stalled = 1'b0;
    logic [7:0] prev = 8'h00;
    while (got < n && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (stalled) check(tx_valid && tx_data == prev, "R8", int'(tx_data), int'(prev));
      tx_ready = bp ? (guard % 3 == 0) : 1'b1;
      if (tx_valid) begin
        if (tx_ready) begin
          check(tx_data == exp_mem[a0 + 7'(got)], tag, int'(tx_data),
                int'(exp_mem[a0 + 7'(got)]));
          got++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          prev = tx_data;
        end
      end
    end
    check(got == n, tag, got, n);
    @(negedge clk);
    tx_ready = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (tx_valid) break;
    end
    check(!tx_valid, tag, int'(tx_valid), 0);
  endtask

  task automatic write_burst(input logic [6:0] a, input int n, input logic [7:0] base,
                             input int gapw);
    send_byte({a, 1'b0});
    for (int i = 0; i < n; i++) begin
      if (i > 0) repeat (gapw) @(negedge clk);
      send_byte(base + 8'(i * 5));
      exp_mem[a + 7'(i)] = base + 8'(i * 5);
    end
    repeat (GAP + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    int r0;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mem_init = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    check(!tx_valid, "R1", int'(tx_valid), 0);
    check(!reg_we, "R1", int'(reg_we), 0);
    check(!reg_rd_en, "R1", int'(reg_rd_en), 0);

    // R5: table of read vectors
    for (int v = 0; v < 6; v++) begin
      issue_read(RD_VEC[v][14:8], RD_VEC[v][7:0]);
      collect(int'(RD_VEC[v][7:0]), 1'b0, RD_VEC[v][14:8], "R5");
    end

    // R3: write burst then read back
    w0 = we_cnt;
    write_burst(7'd12, 5, 8'hA0, 1);
    check(we_cnt - w0 == 5, "R3", we_cnt - w0, 5);
    issue_read(7'd12, 8'd5);
    collect(5, 1'b0, 7'd12, "R3");

    // R2: command byte encoding, 0x82 writes 0x41 and 0x83 reads it
    send_byte(8'h82);
    send_byte(8'h5C);
    exp_mem[7'h41] = 8'h5C;
    repeat (GAP + 4) @(negedge clk);
    send_byte(8'h83);
    send_byte(8'd1);
    collect(1, 1'b0, 7'h41, "R2");

    // R4: gaps under the limit keep the burst; a long gap ends it
    w0 = we_cnt;
    write_burst(7'd30, 3, 8'h11, GAP - 6);
    check(we_cnt - w0 == 3, "R4", we_cnt - w0, 3);
    issue_read(7'd30, 8'd3);
    collect(3, 1'b0, 7'd30, "R4");

    // R6: zero count returns nothing, next byte is a command
    issue_read(7'd8, 8'd0);
    repeat (10) @(negedge clk);
    check(!tx_valid, "R6", int'(tx_valid), 0);
    issue_read(7'd8, 8'd2);
    collect(2, 1'b0, 7'd8, "R6");

    // R7: wrap from 127 to 0 for write and read
    write_burst(7'd126, 4, 8'h70, 1);
    issue_read(7'd126, 8'd4);
    collect(4, 1'b0, 7'd126, "R7");

    // R8 and R11: backpressure, one strobe per byte
    r0 = rd_cnt;
    issue_read(7'd50, 8'd6);
    collect(6, 1'b1, 7'd50, "R8");
    check(rd_cnt - r0 == 6, "R11", rd_cnt - r0, 6);

    // R9: bytes arriving during a response are ignored
    w0 = we_cnt;
    issue_read(7'd60, 8'd5);
    fork
      collect(5, 1'b1, 7'd60, "R9");
      begin
        repeat (3) @(negedge clk);
        send_byte(8'h22);
        send_byte(8'h99);
      end
    join
    check(we_cnt == w0, "R9", we_cnt - w0, 0);
    issue_read(7'h11, 8'd1);
    collect(1, 1'b0, 7'h11, "R9");

    // R10: missing count byte times out
    send_byte({7'd3, 1'b1});
    repeat (GAP + 4) @(negedge clk);
    check(!tx_valid, "R10", int'(tx_valid), 0);
    write_burst(7'd70, 1, 8'hA5, 1);
    issue_read(7'd70, 8'd1);
    collect(1, 1'b0, 7'd70, "R10");

    // R1: reset in the middle of a stalled response
    issue_read(7'd40, 8'd3);
    repeat (10) @(negedge clk);
    check(tx_valid, "R8", int'(tx_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!tx_valid, "R1", int'(tx_valid), 0);
    issue_read(7'd40, 8'd2);
    collect(2, 1'b0, 7'd40, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule